// File: doc/BRIEF.md
# ASID-Ring TLB Lookup and Permission Check

This block translates a virtual address through a small set-associative TLB that sits between the address generation stage and the memory pipeline. Every way is read at the index taken from the address bits just above the 4 KB page offset. An entry matches when its stored virtual page number equals the address page number and its address-space identifier is live in the ring-ASID register. The position of that identifier within the register gives the access ring of the page.

All of this is combinational within the lookup cycle. After a single hit, the block compares the ring against the requested privilege level and decodes the 4-bit page attribute into read, write and execute rights and a cache policy. It then either reports the physical address or raises a fault with a cause code. Instruction fetches and data accesses receive different codes. Entries and the ring register are loaded through a simple one-entry-per-cycle write port.

Top module: `tlb_ring_xlate`

## Requirements
- R1: The ring register holds four 8-bit ASIDs, with slot k in bits 8k+7:8k. It resets to 0x04030201 and takes `ring_wdata` on a clock edge with `ring_wr` high. An entry's ring is the index of the slot equal to its ASID, and the lowest such slot wins. An entry whose ASID is in no slot does not hit.
- R2: An entry with ASID 0 never hits, whatever the ring register holds. Reset clears every entry to zero, so every lookup after reset misses.
- R3: When no way hits, the cause is 1 for a fetch (`lk_ifetch`=1) and 5 for a data access.
- R4: When more than one way hits, the cause is 2 for a fetch and 6 for a data access. This takes precedence over every later check.
- R5: When a single hit's ring is numerically below `lk_priv`, the cause is 3 for a fetch and 7 for a data access. This is checked before permissions.
- R6: For attributes below 12, read is granted, bit 0 grants execute, bit 1 grants write, and bits 3:2 give `lk_cache` (0 bypass, 1 write-back, 2 write-through). Attribute 13 grants read and write with `lk_cache`=3 (isolate). All other attributes grant nothing.
- R7: A fetch reports only execute and a data access reports only read and write. A missing right gives cause 4 (fetch), 8 (load, `lk_store`=0) or 9 (store).
- R8: On success the cause is 0, `lk_fault` is low and `lk_pa` = {entry PPN, `lk_va`[11:0]}. The index is `lk_va`[13:12]. On any fault, `lk_fault` is high and `lk_pa`, the permissions, `lk_cache` and `lk_ring` are all 0.
- R9: With `wr_en` high, a clock edge loads the entry at (`wr_way`, `wr_idx`), and the next lookup sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one TLB entry |
| wr_way | input | 2 | Way of the entry to load |
| wr_idx | input | 2 | Index of the entry to load |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_ppn | input | 20 | Physical page number to store |
| wr_asid | input | 8 | ASID to store |
| wr_attr | input | 4 | Attribute to store |
| ring_wr | input | 1 | Load the ring register |
| ring_wdata | input | 32 | New ring register value |
| lk_va | input | 32 | Virtual address to translate |
| lk_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| lk_store | input | 1 | Data side: 1 = store, 0 = load |
| lk_priv | input | 2 | Requested privilege level |
| lk_pa | output | 32 | Physical address, 0 on fault |
| lk_fault | output | 1 | Translation faulted |
| lk_cause | output | 4 | Cause code, 0 when no fault |
| lk_perm_r | output | 1 | Read granted (data side) |
| lk_perm_w | output | 1 | Write granted (data side) |
| lk_perm_x | output | 1 | Execute granted (fetch side) |
| lk_cache | output | 2 | Cache policy of the page |
| lk_ring | output | 2 | Ring of the hitting entry |

## Verification
The assertions run on every cycle and cover four things:
- that a write lands in the addressed entry and that a ring-register load takes effect;
- that a successful translation keeps the page offset;
- that it grants exactly the right the access side asked for;
- that an isolate page never grants execute.

Only the bench scenarios show the rest: the distinct miss, multi-hit, privilege and prohibition codes, and the order in which those faults are ranked. The scenarios also show that an ASID-0 entry never hits, that reset empties the TLB, and that the lowest matching ring slot wins.

// File: rtl/tlb_ring_pkg.sv
package tlb_ring_pkg;

    localparam int VA_W      = 32;
    localparam int PAGE_W    = 12;
    localparam int VPN_W     = VA_W - PAGE_W;
    localparam int PPN_W     = 20;
    localparam int PA_W      = PPN_W + PAGE_W;
    localparam int ASID_W    = 8;
    localparam int ATTR_W    = 4;
    localparam int RINGS     = 4;
    localparam int RING_W    = $clog2(RINGS);
    localparam int RASID_W   = RINGS * ASID_W;
    localparam logic [RASID_W-1:0] RASID_RST = 32'h0403_0201;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [ASID_W-1:0] asid;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;

    typedef enum logic [3:0] {
        XC_NONE      = 4'd0,
        XC_I_MISS    = 4'd1,
        XC_I_MULTI   = 4'd2,
        XC_I_PRIV    = 4'd3,
        XC_I_PROHIB  = 4'd4,
        XC_D_MISS    = 4'd5,
        XC_D_MULTI   = 4'd6,
        XC_D_PRIV    = 4'd7,
        XC_LD_PROHIB = 4'd8,
        XC_ST_PROHIB = 4'd9
    } xcause_e;

    typedef enum logic [1:0] {
        CM_BYPASS  = 2'd0,
        CM_WBACK   = 2'd1,
        CM_WTHRU   = 2'd2,
        CM_ISOLATE = 2'd3
    } cmode_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    typedef struct packed {
        logic [PA_W-1:0]   pa;
        xcause_e           cause;
        perm_t             perm;
        cmode_e            cm;
        logic [RING_W-1:0] ring;
    } xlate_res_t;

endpackage

// File: rtl/tlb_ring_store.sv
module tlb_ring_store
    import tlb_ring_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int SETS = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [IDX_W-1:0]            wr_idx,
    input  tlb_entry_t                  wr_entry,
    input  logic                        ring_wr,
    input  logic [RASID_W-1:0]          ring_wdata,
    input  logic [IDX_W-1:0]            rd_idx,
    output tlb_entry_t [WAYS-1:0]       rd_entry,
    output logic [RASID_W-1:0]          rasid
);

    typedef struct packed {
        tlb_entry_t [WAYS-1:0][SETS-1:0] tbl;
        logic [RASID_W-1:0]              rasid;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.tbl[wr_way][wr_idx] = wr_entry;
        end
        if (ring_wr) begin
            st_d.rasid = ring_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tbl   <= '0;
            st_q.rasid <= RASID_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_entry[w] = st_q.tbl[w][rd_idx];
        end
    end

    assign rasid = st_q.rasid;

    // R9
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.tbl[$past(wr_way)][$past(wr_idx)] == $past(wr_entry));

    // R1
    ring_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_wr |=> rasid == $past(ring_wdata));

endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
    import tlb_ring_pkg::*;
(
    input  logic [RASID_W-1:0] rasid,
    input  tlb_entry_t         entry,
    input  logic [VPN_W-1:0]   va_vpn,
    output logic               hit,
    output logic [RING_W-1:0]  ring
);

    logic [RINGS-1:0] slot_eq;

    for (genvar r = 0; r < RINGS; r++) begin : g_slot
        assign slot_eq[r] = (rasid[r*ASID_W +: ASID_W] == entry.asid);
    end

    always_comb begin
        ring = '0;
        for (int r = RINGS - 1; r >= 0; r--) begin
            if (slot_eq[r]) begin
                ring = RING_W'(r);
            end
        end
        hit = (entry.vpn == va_vpn) && (entry.asid != '0) && (|slot_eq);
    end

endmodule

// File: rtl/tlb_attr_decode.sv
module tlb_attr_decode
    import tlb_ring_pkg::*;
(
    input  logic [ATTR_W-1:0] attr,
    input  logic              ifetch,
    output perm_t             perm,
    output cmode_e            cmode
);

    perm_t raw;

    always_comb begin
        raw   = '0;
        cmode = CM_BYPASS;
        if (attr < ATTR_W'(12)) begin
            raw.r = 1'b1;
            raw.x = attr[0];
            raw.w = attr[1];
            cmode = cmode_e'(attr[3:2]);
        end else if (attr == ATTR_W'(13)) begin
            raw.r = 1'b1;
            raw.w = 1'b1;
            cmode = CM_ISOLATE;
        end
        perm = raw;
        if (ifetch) begin
            perm.r = 1'b0;
            perm.w = 1'b0;
        end else begin
            perm.x = 1'b0;
        end
    end

endmodule

// File: rtl/tlb_ring_xlate.sv
module tlb_ring_xlate
    import tlb_ring_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int SETS = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WAY_W-1:0]   wr_way,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  logic [ASID_W-1:0]  wr_asid,
    input  logic [ATTR_W-1:0]  wr_attr,
    input  logic               ring_wr,
    input  logic [RASID_W-1:0] ring_wdata,
    input  logic [VA_W-1:0]    lk_va,
    input  logic               lk_ifetch,
    input  logic               lk_store,
    input  logic [RING_W-1:0]  lk_priv,
    output logic [PA_W-1:0]    lk_pa,
    output logic               lk_fault,
    output logic [3:0]         lk_cause,
    output logic               lk_perm_r,
    output logic               lk_perm_w,
    output logic               lk_perm_x,
    output logic [1:0]         lk_cache,
    output logic [RING_W-1:0]  lk_ring
);

    tlb_entry_t                   wr_ent;
    tlb_entry_t [WAYS-1:0]        way_ent;
    logic [RASID_W-1:0]           rasid;
    logic [VPN_W-1:0]             va_vpn;
    logic [IDX_W-1:0]             va_idx;
    logic [WAYS-1:0]              hit_vec;
    logic [WAYS-1:0][RING_W-1:0]  way_ring;
    logic [WAY_W-1:0]             sel_way;
    tlb_entry_t                   sel_ent;
    logic [RING_W-1:0]            sel_ring;
    perm_t                        sel_perm;
    cmode_e                       sel_cm;
    xlate_res_t                   res_d;

    assign wr_ent = '{vpn: wr_vpn, ppn: wr_ppn, asid: wr_asid, attr: wr_attr};
    assign va_vpn = lk_va[VA_W-1:PAGE_W];
    assign va_idx = lk_va[PAGE_W +: IDX_W];

    tlb_ring_store #(.WAYS(WAYS), .SETS(SETS)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_way     (wr_way),
        .wr_idx     (wr_idx),
        .wr_entry   (wr_ent),
        .ring_wr    (ring_wr),
        .ring_wdata (ring_wdata),
        .rd_idx     (va_idx),
        .rd_entry   (way_ent),
        .rasid      (rasid)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_way_match match_i (
            .rasid  (rasid),
            .entry  (way_ent[w]),
            .va_vpn (va_vpn),
            .hit    (hit_vec[w]),
            .ring   (way_ring[w])
        );
    end

    always_comb begin
        sel_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                sel_way = WAY_W'(w);
            end
        end
        sel_ent  = way_ent[sel_way];
        sel_ring = way_ring[sel_way];
    end

    tlb_attr_decode decode_i (
        .attr   (sel_ent.attr),
        .ifetch (lk_ifetch),
        .perm   (sel_perm),
        .cmode  (sel_cm)
    );

    always_comb begin
        logic granted;
        granted = lk_ifetch ? sel_perm.x : (lk_store ? sel_perm.w : sel_perm.r);
        res_d = '0;
        if (hit_vec == '0) begin
            res_d.cause = lk_ifetch ? XC_I_MISS : XC_D_MISS;
        end else if ($countones(hit_vec) > 1) begin
            res_d.cause = lk_ifetch ? XC_I_MULTI : XC_D_MULTI;
        end else if (sel_ring < lk_priv) begin
            res_d.cause = lk_ifetch ? XC_I_PRIV : XC_D_PRIV;
        end else if (!granted) begin
            res_d.cause = lk_ifetch ? XC_I_PROHIB :
                          (lk_store ? XC_ST_PROHIB : XC_LD_PROHIB);
        end else begin
            res_d.cause = XC_NONE;
            res_d.pa    = {sel_ent.ppn, lk_va[PAGE_W-1:0]};
            res_d.perm  = sel_perm;
            res_d.cm    = sel_cm;
            res_d.ring  = sel_ring;
        end
    end

    assign lk_pa     = res_d.pa;
    assign lk_cause  = res_d.cause;
    assign lk_fault  = (res_d.cause != XC_NONE);
    assign lk_perm_r = res_d.perm.r;
    assign lk_perm_w = res_d.perm.w;
    assign lk_perm_x = res_d.perm.x;
    assign lk_cache  = res_d.cm;
    assign lk_ring   = res_d.ring;

    // R8
    pa_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_fault |-> lk_pa[PAGE_W-1:0] == lk_va[PAGE_W-1:0]);

    // R7
    data_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_fault && !lk_ifetch) |-> ((lk_store ? lk_perm_w : lk_perm_r) && !lk_perm_x));

    // R7
    fetch_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_fault && lk_ifetch) |-> (lk_perm_x && !lk_perm_r && !lk_perm_w));

    // R6
    isolate_noexec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_fault && lk_cache == 2'd3) |-> !lk_perm_x);

endmodule

// File: tb/tlb_ring_xlate_tb_top.sv
module tlb_ring_xlate_tb_top;

    typedef struct packed {
        logic [31:0] va;
        logic        ifetch;
        logic        store;
        logic [1:0]  priv;
        logic [3:0]  cause;
        logic [31:0] pa;
        logic [2:0]  rwx;
        logic [1:0]  cm;
        logic [1:0]  ring;
        logic [3:0]  req;
    } vec_t;

    // Fields: va, ifetch, store, priv, cause, pa, rwx, cache, ring, requirement
    localparam vec_t VECS [19] = '{
        '{32'h00001ABC, 1'b0, 1'b0, 2'd0, 4'd0, 32'hABCDEABC, 3'b110, 2'd1, 2'd0, 4'd8}, // R8 load
        '{32'h00001ABC, 1'b0, 1'b1, 2'd0, 4'd0, 32'hABCDEABC, 3'b110, 2'd1, 2'd0, 4'd6}, // R6 store wb
        '{32'h00001ABC, 1'b1, 1'b0, 2'd0, 4'd0, 32'hABCDEABC, 3'b001, 2'd1, 2'd0, 4'd7}, // R7 fetch side
        '{32'h12342010, 1'b0, 1'b0, 2'd2, 4'd0, 32'h55555010, 3'b100, 2'd0, 2'd2, 4'd1}, // R1 ring 2
        '{32'h12342010, 1'b0, 1'b0, 2'd3, 4'd7, 32'h0,        3'b000, 2'd0, 2'd0, 4'd5}, // R5 data priv
        '{32'h12342010, 1'b0, 1'b1, 2'd0, 4'd9, 32'h0,        3'b000, 2'd0, 2'd0, 4'd7}, // R7 store prohib
        '{32'h12342010, 1'b1, 1'b0, 2'd0, 4'd4, 32'h0,        3'b000, 2'd0, 2'd0, 4'd7}, // R7 fetch prohib
        '{32'h00003FFF, 1'b0, 1'b0, 2'd3, 4'd0, 32'h77777FFF, 3'b110, 2'd3, 2'd3, 4'd6}, // R6 isolate
        '{32'h00003FFF, 1'b1, 1'b0, 2'd0, 4'd4, 32'h0,        3'b000, 2'd0, 2'd0, 4'd6}, // R6 isolate no x
        '{32'h40000123, 1'b0, 1'b0, 2'd1, 4'd8, 32'h0,        3'b000, 2'd0, 2'd0, 4'd6}, // R6 attr 14 none
        '{32'h40000123, 1'b0, 1'b0, 2'd2, 4'd7, 32'h0,        3'b000, 2'd0, 2'd0, 4'd5}, // R5 before perms
        '{32'h22222000, 1'b0, 1'b0, 2'd0, 4'd6, 32'h0,        3'b000, 2'd0, 2'd0, 4'd4}, // R4 data multi
        '{32'h22222000, 1'b1, 1'b0, 2'd3, 4'd2, 32'h0,        3'b000, 2'd0, 2'd0, 4'd4}, // R4 fetch multi
        '{32'h33333000, 1'b0, 1'b0, 2'd0, 4'd5, 32'h0,        3'b000, 2'd0, 2'd0, 4'd1}, // R1 asid not in ring
        '{32'h99999000, 1'b1, 1'b0, 2'd0, 4'd1, 32'h0,        3'b000, 2'd0, 2'd0, 4'd3}, // R3 fetch miss
        '{32'h00005444, 1'b1, 1'b0, 2'd0, 4'd0, 32'h0F0F0444, 3'b001, 2'd2, 2'd0, 4'd6}, // R6 wt fetch
        '{32'h00005444, 1'b0, 1'b0, 2'd0, 4'd0, 32'h0F0F0444, 3'b100, 2'd2, 2'd0, 4'd6}, // R6 load wt
        '{32'h00005444, 1'b0, 1'b1, 2'd0, 4'd9, 32'h0,        3'b000, 2'd0, 2'd0, 4'd7}, // R7 no write
        '{32'h00001000, 1'b0, 1'b0, 2'd1, 4'd7, 32'h0,        3'b000, 2'd0, 2'd0, 4'd5}  // R5 ring0 < priv1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_way = '0;
    logic [1:0]  wr_idx = '0;
    logic [19:0] wr_vpn = '0;
    logic [19:0] wr_ppn = '0;
    logic [7:0]  wr_asid = '0;
    logic [3:0]  wr_attr = '0;
    logic        ring_wr = 1'b0;
    logic [31:0] ring_wdata = '0;
    logic [31:0] lk_va = '0;
    logic        lk_ifetch = 1'b0;
    logic        lk_store = 1'b0;
    logic [1:0]  lk_priv = '0;
    logic [31:0] lk_pa;
    logic        lk_fault;
    logic [3:0]  lk_cause;
    logic        lk_perm_r, lk_perm_w, lk_perm_x;
    logic [1:0]  lk_cache;
    logic [1:0]  lk_ring;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tlb_ring_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
        .wr_ppn(wr_ppn), .wr_asid(wr_asid), .wr_attr(wr_attr),
        .ring_wr(ring_wr), .ring_wdata(ring_wdata),
        .lk_va(lk_va), .lk_ifetch(lk_ifetch), .lk_store(lk_store), .lk_priv(lk_priv),
        .lk_pa(lk_pa), .lk_fault(lk_fault), .lk_cause(lk_cause),
        .lk_perm_r(lk_perm_r), .lk_perm_w(lk_perm_w), .lk_perm_x(lk_perm_x),
        .lk_cache(lk_cache), .lk_ring(lk_ring)
    );

    task automatic put_entry(input logic [1:0] w, input logic [1:0] i, input logic [19:0] vpn,
                             input logic [19:0] ppn, input logic [7:0] asid, input logic [3:0] attr);
        @(negedge clk);
        wr_en = 1'b1; wr_way = w; wr_idx = i; wr_vpn = vpn; wr_ppn = ppn;
        wr_asid = asid; wr_attr = attr;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_ring(input logic [31:0] v);
        @(negedge clk);
        ring_wr = 1'b1; ring_wdata = v;
        @(negedge clk);
        ring_wr = 1'b0;
    endtask

    task automatic probe(input vec_t v);
        logic [12:0] got, exp;
        @(negedge clk);
        lk_va = v.va; lk_ifetch = v.ifetch; lk_store = v.store; lk_priv = v.priv;
        #2;
        n_chk++;
        got = {lk_cause, lk_perm_r, lk_perm_w, lk_perm_x, lk_cache, lk_ring, lk_fault};
        exp = {v.cause, v.rwx, v.cm, v.ring, (v.cause != 4'd0)};
        if (got != exp || lk_pa != v.pa) begin
            n_bad++;
            $display("FAIL R%0d va=%h: got cause=%0d pa=%h rwx=%b cache=%0d ring=%0d fault=%b, exp cause=%0d pa=%h rwx=%b cache=%0d ring=%0d",
                     v.req, v.va, lk_cause, lk_pa, {lk_perm_r, lk_perm_w, lk_perm_x}, lk_cache, lk_ring, lk_fault,
                     v.cause, v.pa, v.rwx, v.cm, v.ring);
        end
    endtask

    function automatic vec_t mk(input logic [31:0] va, input logic f, input logic s, input logic [1:0] p,
                                input logic [3:0] c, input logic [31:0] pa, input logic [2:0] rwx,
                                input logic [1:0] cm, input logic [1:0] rg, input logic [3:0] rq);
        return '{va, f, s, p, c, pa, rwx, cm, rg, rq};
    endfunction

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state, empty TLB misses, including page 0 held by cleared entries
        probe(mk(32'h00000000, 1'b0, 1'b0, 2'd0, 4'd5, 32'h0, 3'b000, 2'd0, 2'd0, 4'd2));
        probe(mk(32'h00001ABC, 1'b1, 1'b0, 2'd0, 4'd1, 32'h0, 3'b000, 2'd0, 2'd0, 4'd3)); // R3

        // R9: load the table through the write port
        put_entry(2'd0, 2'd1, 20'h00001, 20'hABCDE, 8'h01, 4'h7);
        put_entry(2'd1, 2'd2, 20'h12342, 20'h55555, 8'h03, 4'h0);
        put_entry(2'd2, 2'd3, 20'h00003, 20'h77777, 8'h04, 4'hD);
        put_entry(2'd3, 2'd0, 20'h40000, 20'h11111, 8'h02, 4'hE);
        put_entry(2'd0, 2'd2, 20'h22222, 20'h22222, 8'h01, 4'h3);
        put_entry(2'd3, 2'd2, 20'h22222, 20'h33333, 8'h02, 4'h3);
        put_entry(2'd1, 2'd3, 20'h33333, 20'h33330, 8'h09, 4'h5);
        put_entry(2'd2, 2'd1, 20'h00005, 20'h0F0F0, 8'h01, 4'h9);

        for (int k = 0; k < 19; k++) begin
            probe(VECS[k]);
        end

        // R1: new ring value brings ASID 9 in at slot 1
        put_ring(32'h04030901);
        probe(mk(32'h33333000, 1'b0, 1'b0, 2'd1, 4'd0, 32'h33330000, 3'b100, 2'd1, 2'd1, 4'd1));
        probe(mk(32'h33333000, 1'b0, 1'b0, 2'd2, 4'd7, 32'h0, 3'b000, 2'd0, 2'd0, 4'd5));

        // R9: overwrite an existing entry, next lookup sees it
        put_entry(2'd0, 2'd1, 20'h00001, 20'h00042, 8'h03, 4'h3);
        probe(mk(32'h00001ABC, 1'b0, 1'b1, 2'd1, 4'd0, 32'h00042ABC, 3'b110, 2'd0, 2'd2, 4'd9));

        // R1: lowest matching slot gives the ring
        put_ring(32'h03030303);
        probe(mk(32'h12342010, 1'b0, 1'b0, 2'd0, 4'd0, 32'h55555010, 3'b100, 2'd0, 2'd0, 4'd1));

        // R2: ASID 0 in the ring register still never hits an entry with ASID 0
        put_ring(32'h04030900);
        probe(mk(32'h00000000, 1'b0, 1'b0, 2'd0, 4'd5, 32'h0, 3'b000, 2'd0, 2'd0, 4'd2));

        // R2: reset clears entries and restores the ring register
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        probe(mk(32'h00005444, 1'b1, 1'b0, 2'd0, 4'd1, 32'h0, 3'b000, 2'd0, 2'd0, 4'd2));
        put_entry(2'd1, 2'd0, 20'h00010, 20'h00AAA, 8'h04, 4'h4);
        probe(mk(32'h00010008, 1'b0, 1'b0, 2'd3, 4'd0, 32'h00AAA008, 3'b100, 2'd1, 2'd3, 4'd1)); // R1 reset ring

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule